// File: doc/BRIEF.md
# Power Domain Sequencer

This block switches one gated logic domain on and off in a fixed order. It drives three controls. The first is the main power switch, which is active low. The second is the memory supply rail, also active low. The third is the isolation clamp, which is active high. Bring-up has two stages, each with a timed wait. The main switch closes first. After a ramp wait, the memory rail turns on. After a shorter memory wait, the clamp opens. Shut-down reverses the order, with one step in each clock cycle and no waits. Each wait is given in microseconds and converted to clock cycles using a clock-frequency parameter.

Enable and disable requests arrive as single-cycle pulses. While a sequence is running, the block raises a busy flag. A request that arrives during that time is held in a one-entry slot, and a later request replaces an earlier one. The held request is acted on in the first cycle after the sequence ends. If the domain is already in the requested state, the request is accepted and nothing changes. A ready flag tells the rest of the chip when the domain may carry traffic.

Top module: `pwrseq_top`

## Requirements
- R1: After reset the outputs are: power switch 1 (open), memory rail 1 (off), isolation 1 (clamped), busy 0, ready 0.
- R2: An accepted enable pulse closes the power switch (drives it to 0) one clock after the pulse is sampled. The memory rail goes to 0 exactly RAMP_US*CLK_MHZ cycles later.
- R3: Isolation drops to 0 exactly MEM_US*CLK_MHZ cycles after the memory rail turns on. Busy is 1 from the cycle the switch closes until isolation drops.
- R4: An accepted disable pulse sets isolation to 1 one clock after it is sampled. The memory rail goes to 1 in the next cycle, and the power switch goes to 1 in the cycle after that. Busy is 1 for the first two of these cycles and returns to 0 with the last one.
- R5: An enable pulse while the domain is up, or a disable pulse while it is off, leaves every output unchanged.
- R6: A pulse that arrives while busy is 1 is held, with a later pulse replacing an earlier one. It is acted on in the first cycle in which busy has returned to 0, so its sequence starts one clock later.
- R7: Ready is 1 exactly when isolation is 0. It rises and falls in the same cycles that isolation falls and rises.
- R8: When enable and disable are pulsed in the same cycle, only the disable is taken.
- R9: The memory rail is never on while the power switch is open, and isolation is never released while the memory rail is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_req | input | 1 | Enable request pulse |
| dn_req | input | 1 | Disable request pulse |
| pwr_sw_n | output | 1 | Main power switch, 0 = on |
| mem_rail_n | output | 1 | Memory supply rail, 0 = on |
| iso_clamp | output | 1 | Isolation clamp, 1 = clamped |
| busy | output | 1 | A sequence is in progress |
| ready | output | 1 | Domain up and unclamped |

## Verification
The bench builds the block with CLK_MHZ = 2. With that value the ramp wait is 20 cycles and the memory wait is 2 cycles. The waits are short enough that each test can run a full bring-up and still send requests part-way through it. They are long enough that an off-by-one error in either wait shifts a visible edge. With a two-cycle memory wait, the held-request cases can land both in the middle of a stage and on a stage boundary.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_UP_PWR = 3'd1,
    ST_UP_MEM = 3'd2,
    ST_ON     = 3'd3,
    ST_DN_ISO = 3'd4,
    ST_DN_MEM = 3'd5
  } seq_state_e;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_UP   = 2'd1,
    REQ_DOWN = 2'd2
  } req_kind_e;

  // Wait length in clock cycles for a duration in microseconds.
  function automatic int us_to_cycles(input int us, input int mhz);
    return us * mhz;
  endfunction

  // Counter width able to hold the larger of two cycle counts.
  function automatic int cnt_width(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

  // Live pulses override the held request; disable wins over enable.
  function automatic req_kind_e merge_req(input logic up, input logic dn,
                                          input req_kind_e held);
    if (dn)      return REQ_DOWN;
    else if (up) return REQ_UP;
    else         return held;
  endfunction

endpackage

// File: rtl/pwrseq_req_hold.sv
module pwrseq_req_hold
  import pwrseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      up_req,
  input  logic      dn_req,
  input  logic      accept,
  output req_kind_e eff_req
);

  req_kind_e held_q;

  assign eff_req = merge_req(up_req, dn_req, held_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_q <= REQ_NONE;
    else if (accept) held_q <= REQ_NONE;
    else             held_q <= eff_req;
  end

endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int RAMP_CYC = 10,
  parameter int MEM_CYC  = 1,
  parameter int CW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  req_kind_e     eff_req,
  input  logic          tmr_expired,
  output seq_state_e    state_q,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          accept,
  output logic          ready_q
);

  localparam logic [CW-1:0] RAMP_LOAD = CW'(RAMP_CYC - 1);
  localparam logic [CW-1:0] MEM_LOAD  = CW'(MEM_CYC - 1);

  seq_state_e state_d;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    unique case (state_q)
      ST_OFF: begin
        accept = 1'b1;
        if (eff_req == REQ_UP) begin
          state_d  = ST_UP_PWR;
          tmr_load = 1'b1;
          tmr_val  = RAMP_LOAD;
        end
      end
      ST_UP_PWR: begin
        if (tmr_expired) begin
          state_d  = ST_UP_MEM;
          tmr_load = 1'b1;
          tmr_val  = MEM_LOAD;
        end
      end
      ST_UP_MEM: if (tmr_expired) state_d = ST_ON;
      ST_ON: begin
        accept = 1'b1;
        if (eff_req == REQ_DOWN) state_d = ST_DN_ISO;
      end
      ST_DN_ISO: state_d = ST_DN_MEM;
      ST_DN_MEM: state_d = ST_OFF;
      default:   state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= (state_d == ST_ON);
    end
  end

endmodule

// File: rtl/pwrseq_outputs.sv
module pwrseq_outputs
  import pwrseq_pkg::*;
(
  input  seq_state_e state_q,
  output logic       pwr_sw_n,
  output logic       mem_rail_n,
  output logic       iso_clamp,
  output logic       busy
);

  always_comb begin
    pwr_sw_n   = (state_q == ST_OFF);
    mem_rail_n = (state_q inside {ST_OFF, ST_UP_PWR, ST_DN_MEM});
    iso_clamp  = (state_q != ST_ON);
    busy       = (state_q inside {ST_UP_PWR, ST_UP_MEM, ST_DN_ISO, ST_DN_MEM});
  end

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int CLK_MHZ = 50,
  parameter int RAMP_US = 10,
  parameter int MEM_US  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_req,
  input  logic dn_req,
  output logic pwr_sw_n,
  output logic mem_rail_n,
  output logic iso_clamp,
  output logic busy,
  output logic ready
);

  localparam int RAMP_CYC = us_to_cycles(RAMP_US, CLK_MHZ);
  localparam int MEM_CYC  = us_to_cycles(MEM_US, CLK_MHZ);
  localparam int CW       = cnt_width(RAMP_CYC, MEM_CYC);

  req_kind_e     eff_req;
  seq_state_e    state_q;
  logic          accept;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_expired;

  pwrseq_req_hold u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .up_req (up_req),
    .dn_req (dn_req),
    .accept (accept),
    .eff_req(eff_req)
  );

  pwrseq_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  pwrseq_fsm #(.RAMP_CYC(RAMP_CYC), .MEM_CYC(MEM_CYC), .CW(CW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .eff_req    (eff_req),
    .tmr_expired(tmr_expired),
    .state_q    (state_q),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .accept     (accept),
    .ready_q    (ready)
  );

  pwrseq_outputs u_out (
    .state_q   (state_q),
    .pwr_sw_n  (pwr_sw_n),
    .mem_rail_n(mem_rail_n),
    .iso_clamp (iso_clamp),
    .busy      (busy)
  );

endmodule

// File: rtl/pwrseq_checker.sv
module pwrseq_checker #(
  parameter int CLK_MHZ = 50,
  parameter int RAMP_US = 10,
  parameter int MEM_US  = 1
) (
  input logic clk,
  input logic rst_n,
  input logic up_req,
  input logic dn_req,
  input logic pwr_sw_n,
  input logic mem_rail_n,
  input logic iso_clamp,
  input logic busy,
  input logic ready
);

  localparam int RAMP_CYC = RAMP_US * CLK_MHZ;
  localparam int MEM_CYC  = MEM_US * CLK_MHZ;

  int ramp_cnt;
  int mem_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp_cnt <= 0;
      mem_cnt  <= 0;
    end else begin
      if (pwr_sw_n)        ramp_cnt <= 0;
      else if (mem_rail_n) ramp_cnt <= ramp_cnt + 1;
      if (mem_rail_n)      mem_cnt  <= 0;
      else if (iso_clamp)  mem_cnt  <= mem_cnt + 1;
    end
  end

  AST_MEM_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rail_n |-> !pwr_sw_n); // R9
  AST_ISO_NEEDS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    !iso_clamp |-> !mem_rail_n); // R9
  AST_READY_MATCHES_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    ready == !iso_clamp); // R7
  AST_RAMP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rail_n) |-> ramp_cnt == RAMP_CYC); // R2
  AST_MEM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_clamp) |-> mem_cnt == MEM_CYC); // R3
  AST_DOWN_MEM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iso_clamp) |=> (mem_rail_n && !pwr_sw_n && busy)); // R4
  AST_DOWN_PWR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_rail_n) && !pwr_sw_n) |=> (pwr_sw_n && !busy)); // R4
  AST_UP_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && up_req && !dn_req) |=> ready); // R5
  AST_DOWN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_sw_n && !busy && dn_req) |=> (pwr_sw_n && !busy)); // R8
  AST_DOWN_WINS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && dn_req) |=> (iso_clamp && busy)); // R8

endmodule

bind pwrseq_top pwrseq_checker #(
  .CLK_MHZ(CLK_MHZ), .RAMP_US(RAMP_US), .MEM_US(MEM_US)
) u_chk (
  .clk(clk), .rst_n(rst_n), .up_req(up_req), .dn_req(dn_req),
  .pwr_sw_n(pwr_sw_n), .mem_rail_n(mem_rail_n), .iso_clamp(iso_clamp),
  .busy(busy), .ready(ready)
);

// File: tb/test_pwrseq_top.sv
module test_pwrseq_top;

  localparam int MHZ = 2;
  localparam int R   = 10 * MHZ;
  localparam int M   = 1 * MHZ;

  // vector order: {pwr_sw_n, mem_rail_n, iso_clamp, busy, ready}
  localparam logic [4:0] V_OFF  = 5'b11100;
  localparam logic [4:0] V_RPWR = 5'b01110;
  localparam logic [4:0] V_RMEM = 5'b00110;
  localparam logic [4:0] V_ON   = 5'b00001;
  localparam logic [4:0] V_DISO = 5'b00110;
  localparam logic [4:0] V_DMEM = 5'b01110;

  typedef struct {
    logic [4:0] vec;
    int         cyc;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_req = 1'b0;
  logic dn_req = 1'b0;
  logic pwr_sw_n, mem_rail_n, iso_clamp, busy, ready;

  int   cyc = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   mon_en = 1'b0;
  bit   done = 1'b0;
  logic [4:0] last_vec;
  exp_t expq[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwrseq_top #(.CLK_MHZ(MHZ), .RAMP_US(10), .MEM_US(1)) i_pwrseq_top (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .dn_req(dn_req),
    .pwr_sw_n(pwr_sw_n), .mem_rail_n(mem_rail_n), .iso_clamp(iso_clamp),
    .busy(busy), .ready(ready)
  );

  function automatic logic [4:0] outv();
    return {pwr_sw_n, mem_rail_n, iso_clamp, busy, ready};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic push(input logic [4:0] v, input int c, input string tag);
    exp_t e;
    e.vec = v; e.cyc = c; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic push_up(input int s, input string tag);
    push(V_RPWR, s,         {tag, " R2"});
    push(V_RMEM, s + R,     {tag, " R2"});
    push(V_ON,   s + R + M, {tag, " R3 R7"});
  endtask

  task automatic push_down(input int s, input string tag);
    push(V_DISO, s,     {tag, " R4 R7"});
    push(V_DMEM, s + 1, {tag, " R4"});
    push(V_OFF,  s + 2, {tag, " R4"});
  endtask

  task automatic send(input logic up, input logic dn, output int k);
    @(negedge clk);
    k = cyc;
    up_req = up;
    dn_req = dn;
    @(negedge clk);
    up_req = 1'b0;
    dn_req = 1'b0;
  endtask

  task automatic settle(input int n, input string req);
    repeat (n) @(negedge clk);
    check(expq.size() == 0, req, "expected changes still pending", expq.size(), 0);
  endtask

  // Monitor: every output change must match the next scoreboard item.
  always @(negedge clk) begin
    if (mon_en) begin
      logic [4:0] cur;
      cur = outv();
      if (cur !== last_vec) begin
        if (expq.size() == 0) begin
          check(1'b0, "R5", "unexpected output change", cur, last_vec);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(cur === e.vec, e.tag, "output vector", cur, e.vec);
          check(cyc == e.cyc, e.tag, "change cycle", cyc, e.cyc);
        end
        last_vec = cur;
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R6 watchdog expired: actual cycle %0d expected finish earlier", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int k;
    int k2;
    repeat (3) @(negedge clk);
    check(outv() === V_OFF, "R1", "outputs in reset", outv(), V_OFF);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(outv() === V_OFF, "R1", "outputs after reset", outv(), V_OFF);
    last_vec = outv();
    mon_en = 1'b1;

    // R2 R3: plain bring-up
    send(1'b1, 1'b0, k);
    push_up(k + 1, "bring-up");
    settle(R + M + 5, "R2");

    // R5: enable while up
    send(1'b1, 1'b0, k);
    settle(8, "R5");
    check(outv() === V_ON, "R5", "enable while up", outv(), V_ON);

    // R8: both while up -> shut-down
    send(1'b1, 1'b1, k);
    push_down(k + 1, "both-on R8");
    settle(6, "R4");

    // R5: disable while off
    send(1'b0, 1'b1, k);
    settle(6, "R5");
    check(outv() === V_OFF, "R5", "disable while off", outv(), V_OFF);

    // R8: both while off -> stays off
    send(1'b1, 1'b1, k);
    settle(6, "R8");
    check(outv() === V_OFF, "R8", "both while off", outv(), V_OFF);

    // R6: disable during ramp is held until bring-up completes
    send(1'b1, 1'b0, k);
    push_up(k + 1, "held-dn");
    repeat (4) @(negedge clk);
    send(1'b0, 1'b1, k2);
    push_down(k + 1 + R + M + 1, "held-dn R6");
    settle(R + M + 8, "R6");

    // R6: enable during shut-down is held until off
    send(1'b1, 1'b0, k);
    push_up(k + 1, "prep");
    settle(R + M + 4, "R2");
    send(1'b0, 1'b1, k);
    push_down(k + 1, "held-up");
    send(1'b1, 1'b0, k2);
    push_up(k + 4, "held-up R6");
    settle(R + M + 8, "R6");

    // R5 R6: repeated enable during ramp, arriving on the memory stage
    send(1'b0, 1'b1, k);
    push_down(k + 1, "prep-off");
    settle(5, "R4");
    send(1'b1, 1'b0, k);
    push_up(k + 1, "dup-up");
    repeat (R - 1) @(negedge clk);
    send(1'b1, 1'b0, k2);
    settle(M + 10, "R5");
    check(outv() === V_ON, "R5", "duplicate enable absorbed", outv(), V_ON);

    send(1'b0, 1'b1, k);
    push_down(k + 1, "final");
    settle(6, "R4");
    check(outv() === V_OFF, "R4", "final off state", outv(), V_OFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule